// File: doc/BRIEF.md
# Command packet framer

The framer takes a stream of 32-bit command words and cuts it into command packets. The first word of each packet carries an opcode in its top byte. The opcode sets how many further words belong to the packet. Drawing packets pass straight through to a packet output. That output marks the final word of each packet with a last flag.

Two kinds of packet do not reach the output. Environment-setting packets are one word long, and they load a bank of eight environment registers. The block derives a short status word from that bank. Pixel-transfer packets are three words long: an opcode, a position word and a size word. They are absorbed, and the block then raises a one-cycle start pulse for an external transfer engine. Textured primitives also patch the texture-page field of environment register 1 as their words pass by.

Both the input and the packet output use valid/ready handshakes. While a packet is being forwarded, the input is tied to the output. `pkt_valid` follows `in_valid`, `in_ready` follows `pkt_ready`, and `pkt_data` equals `in_data`. A stalled output therefore stalls the input, and no word is ever buffered inside the block. Words that are absorbed are always accepted at once. A packet whose remaining words have not yet arrived keeps its place in the framing. Framing resumes when the input becomes valid again.

Top module: `cmd_framer`

## Requirements
- R1: While `rst_n` is low and for the cycle after it, `pkt_valid` (with `in_valid` low), `fb_dirty`, `xfer_start`, `status` and all `env_regs` are zero. The first word after reset is taken as a packet head.
- R2: A head opcode (bits 31:24 of the head word) sets the packet length to 1 plus an extra count. The extra count is 2 for 0x02 and 3 for 0x80. For 0x20–0x3F it is, per aligned group of four opcodes starting at 0x20, 3, 6, 4, 8, 5, 8, 7, 11.
- R3: For 0x40–0x7F the extra count, per aligned group of four starting at 0x40, is 2, 0, 3, 3, 3, 0, 4, 4, 2, 3, 1, 2, 1, 2, 1, 2.
- R4: Every other opcode outside 0xE0–0xE7, 0xA0 and 0xC0 has an extra count of 0. Such a head is forwarded as a one-word packet with `pkt_last` high. In every forwarded packet, `pkt_last` is high on the final word only.
- R5: A head opcode in 0xE0–0xE7 is accepted without being forwarded. From the next cycle on, the whole word is held in environment register `op & 7`, which appears at `env_regs[32*(op&7) +: 32]`. Body words are never decoded as heads, whatever their top byte.
- R6: `status[10:0]` equals bits 10:0 of environment register 1, and `status[12:1... ]` is defined as follows: `status[12:11]` equals bits 1:0 of environment register 6. Status changes only in the cycle after an accepted word.
- R7: For a head with `(op & 0xF4) == 0x24`, bits 8:0 of the fifth packet word replace bits 8:0 of environment register 1. For `(op & 0xF4) == 0x34`, the sixth word is used instead. The update is visible the cycle after that word is accepted.
- R8: Heads 0xA0 and 0xC0, together with their next two words, are accepted without being forwarded. In the cycle after the third word, `xfer_start` is high for exactly one cycle. At that point `xfer_pos` holds the second word, `xfer_size` holds the third word, and `xfer_read` is 1 for 0xC0 and 0 for 0xA0.
- R9: `fb_dirty` is high for one cycle after an accepted head whose opcode lies in 0x02–0xBF (this includes 0xA0). It stays low after any other head and after every body word.
- R10: While forwarding, `pkt_valid` equals `in_valid`, `in_ready` equals `pkt_ready`, and `pkt_data` equals `in_data`. Idle input cycles and output stalls in the middle of a packet neither lose nor add words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_data | input | 32 | Command word |
| pkt_valid | output | 1 | Packet word valid |
| pkt_ready | input | 1 | Downstream can take a packet word |
| pkt_data | output | 32 | Packet word |
| pkt_last | output | 1 | Final word of the packet |
| xfer_start | output | 1 | One-cycle pixel-transfer start pulse |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| fb_dirty | output | 1 | One-cycle pulse after a drawing head |
| status | output | 13 | Status word derived from environment registers |
| env_regs | output | 256 | Eight environment registers, register n at bits 32n+31:32n |

## Verification
The assertions assume that the source of the input stream does not hold `in_valid` high in a way that depends on `in_ready` within the same cycle. They also assume that the sink's `pkt_ready` does not depend on `pkt_valid`. The bench drives both as plain registered values that are set at the falling edge, so no combinational loop forms through the cut-through path. The opcode sweep walks all 256 head values. Every packet is sent in full, so the stream never ends mid-packet except in the dedicated gap-and-stall test. That test resumes the packet and completes it.

// File: rtl/frm_pkg.sv
`timescale 1ns/1ps
package frm_pkg;
  localparam int OP_W  = 8;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {M_HEAD, M_BODY, M_XFER} mode_e;

  // extra words that follow a head opcode
  function automatic logic [CNT_W-1:0] extra_words(input logic [OP_W-1:0] op);
    logic [CNT_W-1:0] n;
    n = '0;
    case (op[7:5])
      3'd0: n = (op == 8'h02) ? 4'd2 : 4'd0;
      3'd1: case (op[4:2])
              3'd0: n = 4'd3;  3'd1: n = 4'd6;
              3'd2: n = 4'd4;  3'd3: n = 4'd8;
              3'd4: n = 4'd5;  3'd5: n = 4'd8;
              3'd6: n = 4'd7;  default: n = 4'd11;
            endcase
      3'd2: case (op[4:2])
              3'd0: n = 4'd2;  3'd1: n = 4'd0;
              3'd5: n = 4'd0;  3'd6, 3'd7: n = 4'd4;
              default: n = 4'd3;
            endcase
      3'd3: case (op[4:2])
              3'd0: n = 4'd2;  3'd1: n = 4'd3;
              3'd2, 3'd4, 3'd6: n = 4'd1;
              default: n = 4'd2;
            endcase
      3'd4: n = (op == 8'h80) ? 4'd3 : 4'd0;
      3'd5: n = (op == 8'hA0) ? 4'd2 : 4'd0;
      3'd6: n = (op == 8'hC0) ? 4'd2 : 4'd0;
      default: n = '0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/frm_op_decode.sv
`timescale 1ns/1ps
module frm_op_decode
  import frm_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  output logic [CNT_W-1:0] extra,
  output logic             is_env,
  output logic             is_xfer,
  output logic             is_read,
  output logic             is_draw,
  output logic [2:0]       tex_word
);
  always_comb begin
    extra    = extra_words(op);
    is_env   = (op[7:3] == 5'b11100);
    is_read  = (op == 8'hC0);
    is_xfer  = (op == 8'hA0) || is_read;
    is_draw  = (op >= 8'h02) && (op <= 8'hBF);
    if ((op & 8'hF4) == 8'h24)      tex_word = 3'd4;
    else if ((op & 8'hF4) == 8'h34) tex_word = 3'd5;
    else                            tex_word = 3'd0;
  end
endmodule

// File: rtl/frm_env_bank.sv
`timescale 1ns/1ps
module frm_env_bank #(
  parameter int DATA_W  = 32,
  parameter int N_ENV   = 8,
  parameter int TEX_W   = 9,
  parameter int ST_LO_W = 11,
  parameter int ST_HI_W = 2,
  localparam int SEL_W  = $clog2(N_ENV),
  localparam int ST_W   = ST_LO_W + ST_HI_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    tex_en,
  input  logic [TEX_W-1:0]        tex_val,
  output logic [N_ENV*DATA_W-1:0] env_flat,
  output logic [ST_W-1:0]         status
);
  localparam int TEX_REG = 1;
  localparam int ST_REG  = 6;

  for (genvar g = 0; g < N_ENV; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        r_q <= '0;
      else if (wr_en && wr_sel == SEL_W'(g))
        r_q <= wr_data;
      else if (tex_en && g == TEX_REG)
        r_q[TEX_W-1:0] <= tex_val;
    end
    assign env_flat[g*DATA_W +: DATA_W] = r_q;
  end

  assign status = {env_flat[ST_REG*DATA_W +: ST_HI_W],
                   env_flat[TEX_REG*DATA_W +: ST_LO_W]};
endmodule

// File: rtl/cmd_framer.sv
`timescale 1ns/1ps
module cmd_framer
  import frm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_ENV   = 8,
  parameter int TEX_W   = 9,
  parameter int ST_LO_W = 11,
  parameter int ST_HI_W = 2,
  localparam int SEL_W  = $clog2(N_ENV),
  localparam int ST_W   = ST_LO_W + ST_HI_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DATA_W-1:0]       in_data,
  output logic                    pkt_valid,
  input  logic                    pkt_ready,
  output logic [DATA_W-1:0]       pkt_data,
  output logic                    pkt_last,
  output logic                    xfer_start,
  output logic                    xfer_read,
  output logic [DATA_W-1:0]       xfer_pos,
  output logic [DATA_W-1:0]       xfer_size,
  output logic                    fb_dirty,
  output logic [ST_W-1:0]         status,
  output logic [N_ENV*DATA_W-1:0] env_regs
);
  mode_e            mode_q;
  logic [CNT_W-1:0] remain_q, idx_q;
  logic [2:0]       tex_q;
  logic             read_q, start_q, dirty_q;
  logic [DATA_W-1:0] pos_q, size_q;

  logic [OP_W-1:0]  head_op;
  logic [CNT_W-1:0] d_extra;
  logic             d_env, d_xfer, d_read, d_draw;
  logic [2:0]       d_tex;
  logic             at_head, absorb, fwd, acc, env_we, tex_en;

  assign head_op = in_data[DATA_W-1 -: OP_W];

  frm_op_decode u_dec (
    .op(head_op), .extra(d_extra), .is_env(d_env), .is_xfer(d_xfer),
    .is_read(d_read), .is_draw(d_draw), .tex_word(d_tex)
  );

  always_comb begin
    at_head   = (mode_q == M_HEAD);
    absorb    = (at_head && (d_env || d_xfer)) || (mode_q == M_XFER);
    fwd       = !absorb;
    pkt_valid = fwd && in_valid;
    in_ready  = fwd ? pkt_ready : 1'b1;
    pkt_data  = in_data;
    pkt_last  = at_head ? (d_extra == '0) : (remain_q == CNT_W'(1));
    acc       = in_valid && in_ready;
    env_we    = acc && at_head && d_env;
    tex_en    = acc && (mode_q == M_BODY) && (tex_q != 3'd0) &&
                (idx_q == CNT_W'(tex_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_HEAD;
      remain_q <= '0;
      idx_q    <= '0;
      tex_q    <= '0;
      read_q   <= 1'b0;
      pos_q    <= '0;
      size_q   <= '0;
      start_q  <= 1'b0;
      dirty_q  <= 1'b0;
    end else begin
      dirty_q <= acc && at_head && d_draw;
      start_q <= acc && (mode_q == M_XFER) && (idx_q == CNT_W'(2));
      if (acc) begin
        case (mode_q)
          M_HEAD: begin
            idx_q <= CNT_W'(1);
            if (d_xfer) begin
              mode_q <= M_XFER;
              read_q <= d_read;
            end else if (!d_env && d_extra != '0) begin
              mode_q   <= M_BODY;
              remain_q <= d_extra;
              tex_q    <= d_tex;
            end
          end
          M_BODY: begin
            idx_q    <= idx_q + CNT_W'(1);
            remain_q <= remain_q - CNT_W'(1);
            if (remain_q == CNT_W'(1)) mode_q <= M_HEAD;
          end
          M_XFER: begin
            idx_q <= idx_q + CNT_W'(1);
            if (idx_q == CNT_W'(1)) begin
              pos_q <= in_data;
            end else begin
              size_q <= in_data;
              mode_q <= M_HEAD;
            end
          end
          default: mode_q <= M_HEAD;
        endcase
      end
    end
  end

  frm_env_bank #(
    .DATA_W(DATA_W), .N_ENV(N_ENV), .TEX_W(TEX_W),
    .ST_LO_W(ST_LO_W), .ST_HI_W(ST_HI_W)
  ) u_env (
    .clk(clk), .rst_n(rst_n), .wr_en(env_we), .wr_sel(head_op[SEL_W-1:0]),
    .wr_data(in_data), .tex_en(tex_en), .tex_val(in_data[TEX_W-1:0]),
    .env_flat(env_regs), .status(status)
  );

  assign xfer_start = start_q;
  assign xfer_read  = read_q;
  assign xfer_pos   = pos_q;
  assign xfer_size  = size_q;
  assign fb_dirty   = dirty_q;
endmodule

// File: rtl/cmd_framer_chk.sv
`timescale 1ns/1ps
module cmd_framer_chk #(
  parameter int ST_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            pkt_valid,
  input logic            pkt_ready,
  input logic            fb_dirty,
  input logic            xfer_start,
  input logic [ST_W-1:0] status
);
  p_out_needs_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> in_valid);

  p_stall_holds_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |-> !in_ready);

  p_status_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(status));

  p_dirty_follows_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_dirty |-> $past(in_valid && in_ready));

  p_start_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  p_start_follows_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(in_valid && in_ready));
endmodule

bind cmd_framer cmd_framer_chk #(.ST_W(ST_W)) u_chk (.*);

// File: tb/sim_cmd_framer.sv
`timescale 1ns/1ps
module sim_cmd_framer;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, pkt_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic in_ready, pkt_valid, pkt_last, xfer_start, xfer_read, fb_dirty;
  logic [DW-1:0] pkt_data, xfer_pos, xfer_size;
  logic [12:0] status;
  logic [8*DW-1:0] env_regs;

  always #2.5 clk = ~clk;

  cmd_framer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_last(pkt_last), .xfer_start(xfer_start),
    .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
    .fb_dirty(fb_dirty), .status(status), .env_regs(env_regs)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] m_env [8];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_extra(input int op);
    int lo[8]  = '{3, 6, 4, 8, 5, 8, 7, 11};
    int mid[16] = '{2, 0, 3, 3, 3, 0, 4, 4, 2, 3, 1, 2, 1, 2, 1, 2};
    if (op == 2) return 2;
    if (op >= 32 && op < 64) return lo[(op - 32) / 4];
    if (op >= 64 && op < 128) return mid[(op - 64) / 4];
    if (op == 128) return 3;
    if (op == 160 || op == 192) return 2;
    return 0;
  endfunction

  function automatic logic [12:0] exp_status();
    return {m_env[6][1:0], m_env[1][10:0]};
  endfunction

  function automatic logic [8*DW-1:0] exp_env();
    logic [8*DW-1:0] v;
    for (int i = 0; i < 8; i++) v[i*DW +: DW] = m_env[i];
    return v;
  endfunction

  // one word, starting at a falling edge; ends at the next falling edge
  task automatic send(input logic [DW-1:0] w, input bit fwd, input bit last,
                      input bit dirty, input string req);
    in_data = w;
    in_valid = 1'b1;
    #1;
    chk(pkt_valid == fwd, req, pkt_valid, fwd);
    chk(in_ready == 1'b1, req, in_ready, 1);
    if (fwd) begin
      chk(pkt_last == last, req, pkt_last, last);
      chk(pkt_data == w, "R10", pkt_data, w);
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(fb_dirty == dirty, "R9", fb_dirty, dirty);
    chk(status == exp_status(), "R6", status, exp_status());
    chk(env_regs == exp_env(), "R5", env_regs[63:0], exp_env() >> 0);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_env[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pkt_valid == 0, "R1", pkt_valid, 0);
    chk(fb_dirty == 0 && xfer_start == 0, "R1", {fb_dirty, xfer_start}, 0);
    chk(status == 0, "R1", status, 0);
    chk(env_regs == '0, "R1", env_regs[63:0], 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep over every head opcode
    for (int op = 0; op < 256; op++) begin
      logic [DW-1:0] head;
      int n;
      bit drw;
      string tag;
      head = {op[7:0], 24'(op * 7919 + 5)};
      drw = (op >= 2 && op <= 191);
      n = 1 + exp_extra(op);
      tag = (op >= 64 && op < 128) ? "R3" : (n == 1 ? "R4" : "R2");
      if (op >= 224 && op < 232) begin
        m_env[op & 7] = head;
        send(head, 0, 0, 0, "R5");
      end else if (op == 160 || op == 192) begin
        logic [DW-1:0] p, s;
        p = 32'(op * 1031 + 17);
        s = 32'(op * 577 + 9) ^ 32'hE5000000;
        send(head, 0, 0, drw, "R8");
        chk(xfer_start == 0, "R8", xfer_start, 0);
        send(p, 0, 0, 0, "R8");
        chk(xfer_start == 0, "R8", xfer_start, 0);
        send(s, 0, 0, 0, "R8");
        chk(xfer_start == 1, "R8", xfer_start, 1);
        chk(xfer_read == (op == 192), "R8", xfer_read, op == 192);
        chk(xfer_pos == p, "R8", xfer_pos, p);
        chk(xfer_size == s, "R8", xfer_size, s);
        @(negedge clk);
        chk(xfer_start == 0, "R8", xfer_start, 0);
      end else begin
        int tw;
        tw = ((op & 8'hF4) == 8'h24) ? 4 : (((op & 8'hF4) == 8'h34) ? 5 : -1);
        for (int k = 0; k < n; k++) begin
          logic [DW-1:0] w;
          w = (k == 0) ? head : (32'(op * 131 + k * 37) ^ 32'hE3C00000);
          if (k == tw) m_env[1][8:0] = w[8:0];
          send(w, 1, k == n - 1, (k == 0) && drw, (k == tw) ? "R7" : tag);
        end
      end
    end

    // R6: set both status sources, then an unrelated register
    m_env[1] = 32'hE1_0005A5;
    send(32'hE1_0005A5, 0, 0, 0, "R6");
    m_env[6] = 32'hE6_000002;
    send(32'hE6_000002, 0, 0, 0, "R6");
    m_env[2] = 32'hE2_FFFFFF;
    send(32'hE2_FFFFFF, 0, 0, 0, "R6");
    chk(status == 13'h15A5, "R6", status, 13'h15A5);

    // R10: stall the head, gaps inside the packet, body word with env-like top byte
    in_data = 32'h2C_000001;
    in_valid = 1'b1;
    pkt_ready = 1'b0;
    #1;
    chk(pkt_valid == 1 && in_ready == 0, "R10", {pkt_valid, in_ready}, 2'b10);
    @(posedge clk);
    #1;
    chk(fb_dirty == 0, "R10", fb_dirty, 0);
    @(negedge clk);
    pkt_ready = 1'b1;
    send(32'h2C_000001, 1, 0, 1, "R10");
    for (int k = 1; k < 9; k++) begin
      logic [DW-1:0] w;
      w = (k == 3) ? 32'hE5_123456 : 32'(k * 4099) | 32'h0000_0100;
      if (k == 4) m_env[1][8:0] = w[8:0];
      repeat (2) begin
        #1;
        chk(pkt_valid == 0, "R10", pkt_valid, 0);
        @(negedge clk);
      end
      send(w, 1, k == 8, 0, (k == 3) ? "R5" : "R10");
    end
    chk(status == exp_status(), "R7", status, exp_status());
    // next word must be a fresh head (single-word packet)
    send(32'hF0_000000, 1, 1, 0, "R4");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule